// File: doc/BRIEF.md
# Serial-Loaded Bank Controller

This block is the bank-switching core of a cartridge controller. The CPU reaches its four internal 5-bit registers through a single data bit: each write to the upper half of the address space (0x8000 to 0xFFFF) shifts data bit 0 into a shift buffer, least significant bit first. The fifth such write commits the assembled value to a register. Bits 14:13 of the address on that fifth write choose which register. A write with data bit 7 set abandons any load in progress and forces program space into a known mode. This lets software recover the loader from an unknown position.

From the register contents the block produces registered bank numbers. Program space is described as two 16 KB windows, in 16 KB units. In one mode a single 32 KB window is used, and the two halves then form an aligned pair. Pattern space is described as two 4 KB windows, in 4 KB units, with an 8 KB paired mode. A 2-bit mirroring code is also produced. A static configuration input serves boards that have half the usual program address lines. When it is set, the switchable 16 KB program bank number is halved.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After a synchronous reset the outputs are as follows: mirror_mode 0, prg_bank_lo 0, prg_bank_hi all ones (31), prg_32k 0, chr_bank_lo 0, chr_bank_hi 1 and chr_8k 1. This matches a control register of 0x0C, all other registers at 0 and an empty shift buffer.
- R2: A strobed write at an address of 0x8000 or above with wr_data bit 7 set empties the shift buffer and the bit counter. It also sets control bits 3:2 to 1 and leaves control bits 4 and 1:0 unchanged.
- R3: Any other strobed write at an address of 0x8000 or above stores wr_data bit 0 at the next buffer position, starting at bit 0. On the fifth such write the 5-bit value goes to the register selected by cpu_addr[14:13] of that write: 0 selects control, 1 selects pattern bank A, 2 selects pattern bank B and 3 selects the program register.
- R4: Writes with cpu_addr below 0x8000 have no effect on any register, the buffer or the counter. This holds even when data bit 7 is set.
- R5: mirror_mode equals control bits 1:0, coded as follows: 0 is single-screen lower, 1 is single-screen upper, 2 is vertical and 3 is horizontal.
- R6: With control bit 3 set, prg_32k is 0. If control bit 2 is also set, prg_bank_lo is the program register and prg_bank_hi is all ones. If control bit 2 is clear, prg_bank_lo is 0 and prg_bank_hi is the program register.
- R7: With control bit 3 clear, prg_32k is 1. prg_bank_lo is the program register with bit 0 cleared, and prg_bank_hi is the same value with bit 0 set.
- R8: With control bit 4 set, chr_8k is 0, chr_bank_lo is pattern bank A and chr_bank_hi is pattern bank B. With control bit 4 clear, chr_8k is 1 and the outputs are pattern bank A with bit 0 cleared and with bit 0 set.
- R9: When half_prg is 1 and control bit 3 is set, the program register is shifted right by one before it is used in R6. In the 32 KB mode of R7, half_prg has no effect.
- R10: Outputs are registered. The outputs do not reflect a write sampled at clock edge E until edge E+1.
- R11: After a commit or an abort, the next load starts again from bit 0. Bits shifted in before an abort are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| half_prg | input | 1 | Board configuration: halve the 16 KB program bank |
| mirror_mode | output | 2 | Mirroring code |
| prg_bank_lo | output | REG_W | 16 KB bank for 0x8000-0xBFFF |
| prg_bank_hi | output | REG_W | 16 KB bank for 0xC000-0xFFFF |
| prg_32k | output | 1 | 1 when program space is one 32 KB window |
| chr_bank_lo | output | REG_W | 4 KB pattern bank for the lower half |
| chr_bank_hi | output | REG_W | 4 KB pattern bank for the upper half |
| chr_8k | output | 1 | 1 when pattern space is one 8 KB window |

## Verification
The bench builds the block with its default register width of 5. At this width, the fixed last program bank is 31 and the commit falls on the fifth write, so every register value and bank pairing can be reached with short write sequences. A behavioural model, built on a bit queue, follows every clock. Directed sequences drive both settings of half_prg, aborts in the middle of a load, ignored low-address writes, and a load whose destination is changed only by the address of its last write.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    DST_CTRL = 2'd0,
    DST_CHRA = 2'd1,
    DST_CHRB = 2'd2,
    DST_PRG  = 2'd3
  } dest_e;

  localparam int CTRL_PRG_16K = 3;
  localparam int CTRL_PRG_LOW = 2;
  localparam int CTRL_CHR_4K  = 4;
endpackage

// File: rtl/sbc_shift_loader.sv
module sbc_shift_loader #(
  parameter int REG_W = 5,
  localparam int CNT_W = (REG_W > 2) ? $clog2(REG_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             abort_bit,
  input  logic             data_bit,
  output logic             abort_o,
  output logic             commit_o,
  output logic [REG_W-1:0] value_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W - 1);

  logic [REG_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    for (int i = 0; i < REG_W; i++) begin
      value_o[i] = (CNT_W'(i) == cnt_q) ? data_bit : sh_q[i];
    end
    abort_o  = strobe && abort_bit;
    commit_o = strobe && !abort_bit && (cnt_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst || abort_o || commit_o) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (strobe) begin
      sh_q  <= value_o;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sbc_reg_file.sv
module sbc_reg_file
  import sbc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             commit,
  input  logic [1:0]       dest,
  input  logic [REG_W-1:0] value,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] chra_q,
  output logic [REG_W-1:0] chrb_q,
  output logic [REG_W-1:0] prg_q
);
  localparam logic [REG_W-1:0] CTRL_INIT  = REG_W'(12);
  localparam logic [REG_W-1:0] ABORT_MASK = REG_W'(12);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_INIT;
      chra_q <= '0;
      chrb_q <= '0;
      prg_q  <= '0;
    end else if (abort) begin
      ctrl_q <= ctrl_q | ABORT_MASK;
    end else if (commit) begin
      case (dest_e'(dest))
        DST_CTRL: ctrl_q <= value;
        DST_CHRA: chra_q <= value;
        DST_CHRB: chrb_q <= value;
        DST_PRG:  prg_q  <= value;
        default:  ctrl_q <= ctrl_q;
      endcase
    end
  end
endmodule

// File: rtl/sbc_bank_map.sv
module sbc_bank_map
  import sbc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_prg,
  input  logic [REG_W-1:0] ctrl,
  input  logic [REG_W-1:0] chra,
  input  logic [REG_W-1:0] chrb,
  input  logic [REG_W-1:0] prg,
  output logic [1:0]       mirror_mode,
  output logic [REG_W-1:0] prg_bank_lo,
  output logic [REG_W-1:0] prg_bank_hi,
  output logic             prg_32k,
  output logic [REG_W-1:0] chr_bank_lo,
  output logic [REG_W-1:0] chr_bank_hi,
  output logic             chr_8k
);
  localparam logic [REG_W-1:0] LAST_BANK = {REG_W{1'b1}};

  mirror_e          mir_d;
  logic [REG_W-1:0] sel_prg;
  logic [REG_W-1:0] plo_d, phi_d, clo_d, chi_d;
  logic             p32_d, c8_d;

  always_comb begin
    mir_d   = mirror_e'(ctrl[1:0]);
    sel_prg = half_prg ? (prg >> 1) : prg;
    if (ctrl[CTRL_PRG_16K]) begin
      p32_d = 1'b0;
      if (ctrl[CTRL_PRG_LOW]) begin
        plo_d = sel_prg;
        phi_d = LAST_BANK;
      end else begin
        plo_d = '0;
        phi_d = sel_prg;
      end
    end else begin
      p32_d = 1'b1;
      plo_d = {prg[REG_W-1:1], 1'b0};
      phi_d = {prg[REG_W-1:1], 1'b1};
    end
    if (ctrl[CTRL_CHR_4K]) begin
      c8_d  = 1'b0;
      clo_d = chra;
      chi_d = chrb;
    end else begin
      c8_d  = 1'b1;
      clo_d = {chra[REG_W-1:1], 1'b0};
      chi_d = {chra[REG_W-1:1], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mirror_mode <= MIR_ONE_LO;
      prg_bank_lo <= '0;
      prg_bank_hi <= LAST_BANK;
      prg_32k     <= 1'b0;
      chr_bank_lo <= '0;
      chr_bank_hi <= REG_W'(1);
      chr_8k      <= 1'b1;
    end else begin
      mirror_mode <= mir_d;
      prg_bank_lo <= plo_d;
      prg_bank_hi <= phi_d;
      prg_32k     <= p32_d;
      chr_bank_lo <= clo_d;
      chr_bank_hi <= chi_d;
      chr_8k      <= c8_d;
    end
  end
endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [15:0]      cpu_addr,
  input  logic [7:0]       wr_data,
  input  logic             half_prg,
  output logic [1:0]       mirror_mode,
  output logic [REG_W-1:0] prg_bank_lo,
  output logic [REG_W-1:0] prg_bank_hi,
  output logic             prg_32k,
  output logic [REG_W-1:0] chr_bank_lo,
  output logic [REG_W-1:0] chr_bank_hi,
  output logic             chr_8k
);
  localparam int CNT_W = (REG_W > 2) ? $clog2(REG_W) : 1;

  logic             strobe, abort, commit;
  logic [REG_W-1:0] value;
  logic [CNT_W-1:0] bit_cnt;
  logic [REG_W-1:0] ctrl_q, chra_q, chrb_q, prg_q;
  logic             unused_inputs;

  assign strobe        = wr_en && cpu_addr[15];
  assign unused_inputs = ^{cpu_addr[12:0], wr_data[6:1]};

  sbc_shift_loader #(.REG_W(REG_W)) u_loader (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .abort_bit(wr_data[7]),
    .data_bit (wr_data[0]),
    .abort_o  (abort),
    .commit_o (commit),
    .value_o  (value),
    .cnt_o    (bit_cnt)
  );

  sbc_reg_file #(.REG_W(REG_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .abort (abort),
    .commit(commit),
    .dest  (cpu_addr[14:13]),
    .value (value),
    .ctrl_q(ctrl_q),
    .chra_q(chra_q),
    .chrb_q(chrb_q),
    .prg_q (prg_q)
  );

  sbc_bank_map #(.REG_W(REG_W)) u_map (
    .clk        (clk),
    .rst        (rst),
    .half_prg   (half_prg),
    .ctrl       (ctrl_q),
    .chra       (chra_q),
    .chrb       (chrb_q),
    .prg        (prg_q),
    .mirror_mode(mirror_mode),
    .prg_bank_lo(prg_bank_lo),
    .prg_bank_hi(prg_bank_hi),
    .prg_32k    (prg_32k),
    .chr_bank_lo(chr_bank_lo),
    .chr_bank_hi(chr_bank_hi),
    .chr_8k     (chr_8k)
  );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int REG_W = 5,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [15:0]      cpu_addr,
  input logic [7:0]       wr_data,
  input logic             commit,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [REG_W-1:0] ctrl_q,
  input logic [REG_W-1:0] chra_q,
  input logic [REG_W-1:0] chrb_q,
  input logic [REG_W-1:0] prg_q,
  input logic [1:0]       mirror_mode,
  input logic [REG_W-1:0] prg_bank_hi,
  input logic [REG_W-1:0] chr_bank_lo,
  input logic [REG_W-1:0] chr_bank_hi,
  input logic             chr_8k
);
  // R2
  abort_forces_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cpu_addr[15] && wr_data[7]) |=> (ctrl_q[3:2] == 2'b11 && bit_cnt == '0));

  // R4
  low_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cpu_addr[15]) |=> ($stable(ctrl_q) && $stable(chra_q) && $stable(chrb_q)
                                  && $stable(prg_q) && $stable(bit_cnt)));

  // R11
  commit_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (bit_cnt == '0));

  // R11
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(bit_cnt) < REG_W));

  // R5
  mirror_tracks_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mirror_mode == $past(ctrl_q[1:0])));

  // R6
  last_bank_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl_q[3:2]) == 2'b11) |-> (prg_bank_hi == {REG_W{1'b1}}));

  // R8
  chr_pair_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    chr_8k |-> (chr_bank_lo[0] == 1'b0 && chr_bank_hi == {chr_bank_lo[REG_W-1:1], 1'b1}));
endmodule

bind serial_bank_ctrl sbc_checker #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .cpu_addr   (cpu_addr),
  .wr_data    (wr_data),
  .commit     (commit),
  .bit_cnt    (bit_cnt),
  .ctrl_q     (ctrl_q),
  .chra_q     (chra_q),
  .chrb_q     (chrb_q),
  .prg_q      (prg_q),
  .mirror_mode(mirror_mode),
  .prg_bank_hi(prg_bank_hi),
  .chr_bank_lo(chr_bank_lo),
  .chr_bank_hi(chr_bank_hi),
  .chr_8k     (chr_8k)
);

// File: tb/serial_bank_ctrl_test.sv
`timescale 1ns/1ps
module serial_bank_ctrl_test;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [15:0]  cpu_addr = 16'h0000;
  logic [7:0]   wr_data = 8'h00;
  logic         half_prg = 1'b0;
  logic [1:0]   mirror_mode;
  logic [W-1:0] prg_bank_lo, prg_bank_hi, chr_bank_lo, chr_bank_hi;
  logic         prg_32k, chr_8k;

  int errors = 0;
  int checks = 0;
  bit started = 0;
  bit done = 0;

  serial_bank_ctrl #(.REG_W(W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cpu_addr(cpu_addr), .wr_data(wr_data),
    .half_prg(half_prg), .mirror_mode(mirror_mode), .prg_bank_lo(prg_bank_lo),
    .prg_bank_hi(prg_bank_hi), .prg_32k(prg_32k), .chr_bank_lo(chr_bank_lo),
    .chr_bank_hi(chr_bank_hi), .chr_8k(chr_8k)
  );

  always #2 clk = ~clk;

  // Reference model: integer registers and a queue of shifted bits
  int m_ctrl, m_chra, m_chrb, m_prg;
  bit m_bits[$];
  int e_mir, e_plo, e_phi, e_p32, e_clo, e_chi, e_c8;
  string e_ptag;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 12; m_chra = 0; m_chrb = 0; m_prg = 0;
      m_bits.delete();
      e_mir = 0; e_plo = 0; e_phi = 31; e_p32 = 0; e_clo = 0; e_chi = 1; e_c8 = 1;
      e_ptag = "R1";
      started = 1;
    end else begin
      e_mir = m_ctrl % 4;
      if ((m_ctrl / 8) % 2 == 1) begin
        int sw;
        sw = half_prg ? m_prg / 2 : m_prg;
        e_p32 = 0;
        e_ptag = half_prg ? "R9" : "R6";
        if ((m_ctrl / 4) % 2 == 1) begin e_plo = sw; e_phi = 31; end
        else begin e_plo = 0; e_phi = sw; end
      end else begin
        e_p32 = 1; e_ptag = "R7";
        e_plo = m_prg - (m_prg % 2); e_phi = e_plo + 1;
      end
      if ((m_ctrl / 16) % 2 == 1) begin e_c8 = 0; e_clo = m_chra; e_chi = m_chrb; end
      else begin e_c8 = 1; e_clo = m_chra - (m_chra % 2); e_chi = e_clo + 1; end
      if (wr_en && cpu_addr >= 16'h8000) begin
        if (wr_data[7]) begin
          m_bits.delete();
          if ((m_ctrl / 4) % 4 != 3) m_ctrl = m_ctrl - (m_ctrl % 16) + 12 + (m_ctrl % 4);
        end else begin
          m_bits.push_back(wr_data[0]);
          if (m_bits.size() == 5) begin
            int v;
            v = 0;
            foreach (m_bits[i]) v += int'(m_bits[i]) << i;
            m_bits.delete();
            case ((int'(cpu_addr) - 32768) / 8192)
              0: m_ctrl = v;
              1: m_chra = v;
              2: m_chrb = v;
              default: m_prg = v;
            endcase
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      chk("R5 mirror", int'(mirror_mode), e_mir);
      chk({e_ptag, " prg_lo"}, int'(prg_bank_lo), e_plo);
      chk({e_ptag, " prg_hi"}, int'(prg_bank_hi), e_phi);
      chk({e_ptag, " prg_32k"}, int'(prg_32k), e_p32);
      chk("R8 chr_lo", int'(chr_bank_lo), e_clo);
      chk("R8 chr_hi", int'(chr_bank_hi), e_chi);
      chk("R8 chr_8k", int'(chr_8k), e_c8);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cpu_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] a, input int v);
    for (int i = 0; i < 5; i++) wr(a, 8'((v >> i) & 1));
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // r1_ reset state
    chk("R1 mirror", int'(mirror_mode), 0);
    chk("R1 prg_lo", int'(prg_bank_lo), 0);
    chk("R1 prg_hi", int'(prg_bank_hi), 31);
    chk("R1 chr_hi", int'(chr_bank_hi), 1);
    chk("R1 chr_8k", int'(chr_8k), 1);

    load(16'h8000, 5'h1F);
    load(16'hE000, 5'h0B);
    load(16'hA000, 5'h13);
    load(16'hC000, 5'h07);
    settle();
    chk("R3 mirror", int'(mirror_mode), 3);
    chk("R6 prg_lo", int'(prg_bank_lo), 11);
    chk("R6 prg_hi", int'(prg_bank_hi), 31);
    chk("R8 chr_lo", int'(chr_bank_lo), 19);
    chk("R8 chr_hi", int'(chr_bank_hi), 7);

    // R10: five writes of 0x1D to control, observe the output latency
    for (int i = 0; i < 5; i++) wr(16'h8000, 8'((8'h1D >> i) & 1));
    chk("R10 mirror one cycle after commit", int'(mirror_mode), 3);
    @(negedge clk);
    chk("R10 mirror two cycles after commit", int'(mirror_mode), 1);

    half_prg = 1'b1;
    load(16'h8000, 5'h08);
    settle();
    chk("R9 prg_lo", int'(prg_bank_lo), 0);
    chk("R9 prg_hi", int'(prg_bank_hi), 5);
    chk("R8 chr_lo 8k", int'(chr_bank_lo), 18);
    load(16'h8000, 5'h00);
    settle();
    chk("R9 no effect in 32k lo", int'(prg_bank_lo), 10);
    chk("R7 32k hi", int'(prg_bank_hi), 11);
    chk("R7 32k flag", int'(prg_32k), 1);
    half_prg = 1'b0;

    wr(16'h8000, 8'h01);
    wr(16'h8000, 8'h01);
    wr(16'h8000, 8'h80);
    settle();
    chk("R2 prg_32k after abort", int'(prg_32k), 0);
    chk("R2 prg_lo after abort", int'(prg_bank_lo), 11);
    chk("R2 mirror kept", int'(mirror_mode), 0);
    load(16'hE000, 5'h06);
    settle();
    chk("R11 load after abort", int'(prg_bank_lo), 6);

    wr(16'h6000, 8'h80);
    wr(16'h6000, 8'h01);
    wr(16'h4000, 8'h01);
    wr(16'h7FFF, 8'h01);
    settle();
    chk("R4 prg_lo", int'(prg_bank_lo), 6);
    chk("R4 prg_32k", int'(prg_32k), 0);
    load(16'hE000, 5'h03);
    settle();
    chk("R4 counter untouched", int'(prg_bank_lo), 3);

    // R3: the fifth write's address chooses the destination
    for (int i = 0; i < 4; i++) wr(16'hA000, 8'((8'h15 >> i) & 1));
    wr(16'hE000, 8'h01);
    settle();
    chk("R3 dest from fifth write", int'(prg_bank_lo), 21);
    chk("R3 chr unchanged", int'(chr_bank_lo), 18);

    settle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4ns * 200000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule